// File: doc/BRIEF.md
# DSI Video Packet Decoder

This block sits behind a four-lane serial display receiver that has already turned each lane into bytes. Each cycle with `lane_vld` high it takes one byte from every physical lane. A software-set selector field maps the physical lanes onto logical lanes. The block then restores the original byte order of the high-speed burst and parses the packets it finds, one after another. It supports video-mode traffic in non-burst form with sync pulses. Sync events drive level VSYNC and HSYNC outputs. Pixel-stream payloads are repacked into 24-bit pixels with a one-cycle data-enable strobe. Null and blanking packets are consumed without effect.

The virtual-channel bits, the header ECC byte and the payload checksum are read past and never checked. A data type outside the supported set raises a sticky error flag. If that type has the long form, its payload is skipped by its word count, so parsing stays aligned. A debug tap exposes the merged byte stream and marks the first byte of every packet.

The parsing clock is assumed to run at four times the lane byte rate. A new lane word therefore arrives at most once every four cycles, and the merged stream is carried as one byte per cycle. `burst_act` frames each high-speed burst. When it is low, the parser returns to expecting a packet header.

Top module: `dsi_vid_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `vsync`, `hsync`, `pix_de`, `err_type`, `dbg_vld` and `dbg_sop` are 0.
- R2: Bits [2i+1:2i] of `lane_order` give the physical lane (0 to 3) whose byte becomes logical lane i. Physical lane p occupies `lane_data[8p+7:8p]`. The value 0xE4 is the identity mapping.
- R3: Logical lane i carries byte 4k+i of the burst. The merged stream on `dbg_byte`/`dbg_vld` restores the burst order at one byte per cycle. `dbg_sop` is high together with `dbg_vld` exactly on the first byte of each packet.
- R4: Short packet data type 0x01 sets `vsync` and 0x11 clears it. Type 0x21 sets `hsync` and 0x31 clears it. Type 0x08 (end of transmission) changes no output. The data type is bits [5:0] of the first header byte.
- R5: In a long packet of type 0x3E, each 3 payload bytes form one pixel. `pix_data` is {first, second, third} byte (red in [23:16], green in [15:8], blue in [7:0]).
- R6: In a long packet of type 0x2E, pixels are also formed from 3 payload bytes in the same order. The low 2 bits of each byte are forced to 0 in `pix_data`.
- R7: Long packets of type 0x09 (null) and 0x19 (blanking) are skipped by word count. Their payload does not change `vsync`, `hsync` or `err_type`, and it produces no `pix_de`.
- R8: Packets may follow back to back inside one burst. A long packet is a 4-byte header with word count = byte1 + 256·byte2, then the payload bytes, then 2 checksum bytes. A short packet is 4 bytes. A long packet with word count 0 carries no payload.
- R9: Header bits [7:6] (virtual channel), the ECC byte and the checksum bytes do not affect decoding.
- R10: A data type outside {0x01,0x11,0x21,0x31,0x08,0x09,0x19,0x2E,0x3E} sets `err_type`, which stays set until reset. A type is of the long form when bit 3 is 1 and bits [2:0] are not all 0. Such a packet's payload is skipped by its word count, and the next packet is still decoded.
- R11: When `burst_act` is low, the parser drops any packet in progress and treats the next merged byte of a later burst as a header start.
- R12: `pix_de` is a one-cycle strobe in the cycle after the third byte of a pixel leaves the merged stream. It never pulses in two consecutive cycles. Leftover bytes that do not complete a pixel at the end of a packet are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parsing clock, four times the lane byte rate |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_act | input | 1 | High for the duration of a high-speed burst |
| lane_vld | input | 1 | One byte valid on every physical lane |
| lane_data | input | 32 | Physical lane bytes, lane p in bits [8p+7:8p] |
| lane_order | input | 8 | Logical-to-physical lane selectors, 2 bits per logical lane |
| pix_data | output | 24 | Last assembled pixel, red in the top byte |
| pix_de | output | 1 | Pixel strobe, one cycle per pixel |
| vsync | output | 1 | Vertical sync level |
| hsync | output | 1 | Horizontal sync level |
| err_type | output | 1 | Sticky flag for an unsupported data type |
| dbg_byte | output | 8 | Merged byte stream |
| dbg_vld | output | 1 | Merged byte valid |
| dbg_sop | output | 1 | Merged byte is the first byte of a packet |

## Verification
The bench sends single sync packets, with and without junk in the virtual-channel and ECC fields. This separates data-type decoding from header parsing. Both pixel formats use payloads whose low bits are non-zero, so byte order and the 18-bit truncation show up in the pixel values. One burst mixes sync, pixel and end-of-transmission packets, with a byte-by-byte comparison of the debug stream. The same packet is also replayed under a reversed lane map, to tell merging faults from parsing faults. Null, blanking and unknown long packets carry payload bytes that look like sync headers, and a burst is cut mid-packet. A parser that loses its word count or ignores the burst end would therefore change a sync level or emit pixels.

// File: rtl/dsi_vid_pkg.sv
// Shared constants and types for the DSI video packet decoder.
// Assumes byte-wide lanes and the fixed set of video-mode data types.
package dsi_vid_pkg;

    localparam int HDR_LEN = 4;
    localparam int CRC_LEN = 2;
    localparam int DT_W    = 6;

    localparam logic [DT_W-1:0] DT_VS_START = 6'h01;
    localparam logic [DT_W-1:0] DT_VS_END   = 6'h11;
    localparam logic [DT_W-1:0] DT_HS_START = 6'h21;
    localparam logic [DT_W-1:0] DT_HS_END   = 6'h31;
    localparam logic [DT_W-1:0] DT_EOT      = 6'h08;
    localparam logic [DT_W-1:0] DT_NULL     = 6'h09;
    localparam logic [DT_W-1:0] DT_BLANK    = 6'h19;
    localparam logic [DT_W-1:0] DT_PIX18L   = 6'h2E;
    localparam logic [DT_W-1:0] DT_PIX24    = 6'h3E;

    typedef enum logic [1:0] {
        ST_HDR = 2'd0,
        ST_PAY = 2'd1,
        ST_CRC = 2'd2
    } pstate_t;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_P24  = 2'd1,
        FMT_P18  = 2'd2
    } pfmt_t;

endpackage

// File: rtl/dsi_lane_merge.sv
// Lane merger: reorders the physical lanes into logical lanes and replays
// the resulting word as a one-byte-per-cycle stream, logical lane 0 first.
// Assumes a new word arrives no sooner than LANES cycles after the last one.
module dsi_lane_merge #(
    parameter int LANES = 4,
    parameter int BW    = 8,
    localparam int SW   = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                burst_act,
    input  logic                lane_vld,
    input  logic [LANES*BW-1:0] lane_data,
    input  logic [LANES*SW-1:0] lane_order,
    output logic [BW-1:0]       mrg_byte,
    output logic                mrg_vld
);

    logic [LANES-1:0][BW-1:0] word;
    logic [LANES-1:0][BW-1:0] hold;
    logic [SW-1:0]            idx;
    logic                     act;

    // Logical lane i takes the physical lane named by its selector field.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SW-1:0] sel;
        assign sel     = lane_order[i*SW +: SW];
        assign word[i] = lane_data[sel*BW +: BW];
    end

    // Capture a word and step through its bytes one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !burst_act) begin
            hold <= '0;
            idx  <= '0;
            act  <= 1'b0;
        end else if (lane_vld) begin
            hold <= word;
            idx  <= '0;
            act  <= 1'b1;
        end else if (act) begin
            idx <= idx + 1'b1;
            if (idx == SW'(LANES-1)) act <= 1'b0;
        end
    end

    assign mrg_byte = hold[idx];
    assign mrg_vld  = act;

endmodule

// File: rtl/dsi_pkt_parser.sv
// Packet parser: walks header, payload and checksum of each packet in the
// merged byte stream, applies sync events and forwards pixel payload bytes.
// Assumes the stream restarts at a header whenever a burst ends.
module dsi_pkt_parser
    import dsi_vid_pkg::*;
#(
    parameter int BW   = 8,
    parameter int WC_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          burst_act,
    input  logic [BW-1:0] in_byte,
    input  logic          in_vld,
    output logic          sop,
    output logic          pay_vld,
    output logic [BW-1:0] pay_byte,
    output logic          pay_restart,
    output logic          pay_is18,
    output logic          vsync,
    output logic          hsync,
    output logic          err_type
);

    localparam int HC_W = $clog2(HDR_LEN);

    pstate_t         st;
    pfmt_t           fmt;
    logic [HC_W-1:0] hcnt;
    logic            ccnt;
    logic [DT_W-1:0] dt;
    logic [BW-1:0]   wc_lo;
    logic [BW-1:0]   wc_hi;
    logic [WC_W-1:0] rem;
    logic [WC_W-1:0] wc;
    logic            hdr_done;
    logic            is_long;
    logic            known_long;

    assign wc         = WC_W'({wc_hi, wc_lo});
    assign hdr_done   = in_vld && (st == ST_HDR) && (hcnt == HC_W'(HDR_LEN-1));
    assign is_long    = dt[3] && (dt[2:0] != 3'd0);
    assign known_long = (dt == DT_NULL) || (dt == DT_BLANK) ||
                        (dt == DT_PIX18L) || (dt == DT_PIX24);

    // Packet state machine with sync and error side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_HDR; fmt <= FMT_NONE; hcnt <= '0; ccnt <= 1'b0;
            dt <= '0; wc_lo <= '0; wc_hi <= '0; rem <= '0;
            vsync <= 1'b0; hsync <= 1'b0; err_type <= 1'b0;
        end else if (!burst_act) begin
            st <= ST_HDR; fmt <= FMT_NONE; hcnt <= '0; ccnt <= 1'b0;
        end else if (in_vld) begin
            unique case (st)
                ST_HDR: begin
                    hcnt <= hcnt + 1'b1;
                    if (hcnt == HC_W'(0)) dt    <= in_byte[DT_W-1:0];
                    if (hcnt == HC_W'(1)) wc_lo <= in_byte;
                    if (hcnt == HC_W'(2)) wc_hi <= in_byte;
                    if (hdr_done) begin
                        hcnt <= '0;
                        if (is_long) begin
                            if (!known_long) err_type <= 1'b1;
                            fmt  <= (dt == DT_PIX24)  ? FMT_P24 :
                                    (dt == DT_PIX18L) ? FMT_P18 : FMT_NONE;
                            rem  <= wc;
                            ccnt <= 1'b0;
                            st   <= (wc == '0) ? ST_CRC : ST_PAY;
                        end else begin
                            unique case (dt)
                                DT_VS_START: vsync <= 1'b1;
                                DT_VS_END:   vsync <= 1'b0;
                                DT_HS_START: hsync <= 1'b1;
                                DT_HS_END:   hsync <= 1'b0;
                                DT_EOT:      ;
                                default:     err_type <= 1'b1;
                            endcase
                        end
                    end
                end
                ST_PAY: begin
                    rem <= rem - 1'b1;
                    if (rem == WC_W'(1)) st <= ST_CRC;
                end
                ST_CRC: begin
                    ccnt <= 1'b1;
                    if (ccnt) begin
                        st  <= ST_HDR;
                        fmt <= FMT_NONE;
                    end
                end
                default: st <= ST_HDR;
            endcase
        end
    end

    assign sop         = in_vld && (st == ST_HDR) && (hcnt == '0);
    assign pay_vld     = in_vld && (st == ST_PAY) && (fmt != FMT_NONE);
    assign pay_byte    = in_byte;
    assign pay_restart = hdr_done || !burst_act;
    assign pay_is18    = (fmt == FMT_P18);

endmodule

// File: rtl/dsi_pix_pack.sv
// Pixel packer: gathers three payload bytes into one pixel and strobes it.
// In the 18-bit loose format the low bits of each component are zeroed.
module dsi_pix_pack #(
    parameter int BW    = 8,
    parameter int C18_W = 6,
    localparam int PW   = 3*BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          in_vld,
    input  logic [BW-1:0] in_byte,
    input  logic          is18,
    output logic [PW-1:0] pix_data,
    output logic          pix_de
);

    localparam logic [BW-1:0] MASK18 = {{C18_W{1'b1}}, {(BW-C18_W){1'b0}}};

    logic [1:0]    phase;
    logic [BW-1:0] c0;
    logic [BW-1:0] c1;
    logic [BW-1:0] cm;

    assign cm = is18 ? (in_byte & MASK18) : in_byte;

    // Collect components and publish a pixel on every third byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0; c0 <= '0; c1 <= '0; pix_data <= '0; pix_de <= 1'b0;
        end else begin
            pix_de <= 1'b0;
            if (restart) begin
                phase <= '0;
            end else if (in_vld) begin
                unique case (phase)
                    2'd0: begin c0 <= cm; phase <= 2'd1; end
                    2'd1: begin c1 <= cm; phase <= 2'd2; end
                    default: begin
                        pix_data <= {c0, c1, cm};
                        pix_de   <= 1'b1;
                        phase    <= 2'd0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dsi_vid_decoder.sv
// DSI video packet decoder top: lane merge, packet parse, pixel pack.
// Assumes four active lanes and a parsing clock four times the byte rate.
module dsi_vid_decoder #(
    parameter int LANES = 4,
    parameter int BW    = 8,
    parameter int WC_W  = 16,
    localparam int SW   = $clog2(LANES),
    localparam int PW   = 3*BW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                burst_act,
    input  logic                lane_vld,
    input  logic [LANES*BW-1:0] lane_data,
    input  logic [LANES*SW-1:0] lane_order,
    output logic [PW-1:0]       pix_data,
    output logic                pix_de,
    output logic                vsync,
    output logic                hsync,
    output logic                err_type,
    output logic [BW-1:0]       dbg_byte,
    output logic                dbg_vld,
    output logic                dbg_sop
);

    logic [BW-1:0] mrg_byte;
    logic          mrg_vld;
    logic          pay_vld;
    logic [BW-1:0] pay_byte;
    logic          pay_restart;
    logic          pay_is18;

    dsi_lane_merge #(.LANES(LANES), .BW(BW)) u_merge (
        .clk(clk), .rst_n(rst_n), .burst_act(burst_act),
        .lane_vld(lane_vld), .lane_data(lane_data), .lane_order(lane_order),
        .mrg_byte(mrg_byte), .mrg_vld(mrg_vld)
    );

    dsi_pkt_parser #(.BW(BW), .WC_W(WC_W)) u_parse (
        .clk(clk), .rst_n(rst_n), .burst_act(burst_act),
        .in_byte(mrg_byte), .in_vld(mrg_vld), .sop(dbg_sop),
        .pay_vld(pay_vld), .pay_byte(pay_byte), .pay_restart(pay_restart),
        .pay_is18(pay_is18), .vsync(vsync), .hsync(hsync), .err_type(err_type)
    );

    dsi_pix_pack #(.BW(BW)) u_pack (
        .clk(clk), .rst_n(rst_n), .restart(pay_restart),
        .in_vld(pay_vld), .in_byte(pay_byte), .is18(pay_is18),
        .pix_data(pix_data), .pix_de(pix_de)
    );

    assign dbg_byte = mrg_byte;
    assign dbg_vld  = mrg_vld;

endmodule

// File: rtl/dsi_vid_checker.sv
// Property checker for the DSI video packet decoder, bound to its top.
module dsi_vid_checker (
    input logic clk,
    input logic rst_n,
    input logic pix_de,
    input logic vsync,
    input logic hsync,
    input logic err_type,
    input logic dbg_vld,
    input logic dbg_sop
);

    // Error flag never clears outside reset.
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_type |=> err_type);

    // A pixel strobe follows a merged byte and is never two cycles long.
    p_de_after_byte_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_de |-> $past(dbg_vld));
    p_de_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pix_de |=> !pix_de);

    // Packet start marker only accompanies a valid merged byte.
    p_sop_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_sop |-> dbg_vld);

    // Sync levels move only after a merged byte has been consumed.
    p_vsync_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsync) |-> $past(dbg_vld));
    p_hsync_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hsync) |-> $past(dbg_vld));

endmodule

bind dsi_vid_decoder dsi_vid_checker u_chk (
    .clk(clk), .rst_n(rst_n), .pix_de(pix_de), .vsync(vsync),
    .hsync(hsync), .err_type(err_type), .dbg_vld(dbg_vld), .dbg_sop(dbg_sop)
);

// File: tb/sim_dsi_vid_decoder.sv
// Directed bench for the DSI video packet decoder.
module sim_dsi_vid_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        burst_act = 1'b0;
    logic        lane_vld = 1'b0;
    logic [31:0] lane_data = '0;
    logic [7:0]  lane_order = 8'hE4;
    logic [23:0] pix_data;
    logic        pix_de, vsync, hsync, err_type;
    logic [7:0]  dbg_byte;
    logic        dbg_vld, dbg_sop;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]  bq [0:255];
    int          nb = 0;
    logic [23:0] pq [0:63];
    int          np = 0;
    logic [7:0]  dq [0:255];
    logic        sq [0:255];
    int          nd = 0;

    always #2 clk = ~clk;

    dsi_vid_decoder u0 (
        .clk(clk), .rst_n(rst_n), .burst_act(burst_act), .lane_vld(lane_vld),
        .lane_data(lane_data), .lane_order(lane_order), .pix_data(pix_data),
        .pix_de(pix_de), .vsync(vsync), .hsync(hsync), .err_type(err_type),
        .dbg_byte(dbg_byte), .dbg_vld(dbg_vld), .dbg_sop(dbg_sop)
    );

    // Record outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && pix_de && np < 64) begin pq[np] = pix_data; np++; end
        if (rst_n && dbg_vld && nd < 256) begin
            dq[nd] = dbg_byte; sq[nd] = dbg_sop; nd++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        bq[nb] = b; nb++;
    endtask

    task automatic put_short(input logic [7:0] di, input logic [7:0] ecc);
        put(di); put(8'h00); put(8'h00); put(ecc);
    endtask

    task automatic put_hdr(input logic [7:0] di, input int wc);
        put(di); put(wc[7:0]); put(wc[15:8]); put(8'h5A);
    endtask

    task automatic put_crc();
        put(8'hC3); put(8'h3C);
    endtask

    task automatic clear_logs();
        np = 0; nd = 0;
    endtask

    // Play the queued bytes as one burst through the current lane map.
    task automatic send_burst();
        burst_act = 1'b1;
        for (int w = 0; w < nb/4; w++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                int sel;
                sel = int'(lane_order[2*i +: 2]);
                lane_data[sel*8 +: 8] = bq[4*w+i];
            end
            lane_vld = 1'b1;
            @(negedge clk);
            lane_vld = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        burst_act = 1'b0;
        repeat (2) @(negedge clk);
        nb = 0;
    endtask

    task automatic t_reset();
        chk(vsync == 0 && hsync == 0, "R1 sync idle", {vsync, hsync}, 0);
        chk(pix_de == 0 && err_type == 0, "R1 de/err idle", {pix_de, err_type}, 0);
        chk(dbg_vld == 0 && dbg_sop == 0, "R1 debug idle", {dbg_vld, dbg_sop}, 0);
    endtask

    task automatic t_sync();
        put_short(8'hC1, 8'hFF);              // V start, VC=3, junk ECC (R9)
        send_burst();
        chk(vsync == 1, "R4 R9 vsync start", vsync, 1);
        put_short(8'h21, 8'h00);
        send_burst();
        chk(hsync == 1 && vsync == 1, "R4 hsync start", {vsync, hsync}, 3);
        put_short(8'h51, 8'h12);              // V end, VC=1
        put_short(8'h31, 8'h34);
        send_burst();
        chk(vsync == 0 && hsync == 0, "R4 R9 sync ends", {vsync, hsync}, 0);
    endtask

    task automatic t_pix24();
        clear_logs();
        put_hdr(8'h3E, 6);
        put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55); put(8'h66);
        put_crc();
        send_burst();
        chk(np == 2, "R5 R12 pixel count", np, 2);
        chk(pq[0] == 24'h112233, "R5 pixel 0", pq[0], 24'h112233);
        chk(pq[1] == 24'h445566, "R5 pixel 1", pq[1], 24'h445566);
    endtask

    task automatic t_pix18();
        clear_logs();
        put_hdr(8'h2E, 6);
        put(8'hFF); put(8'h81); put(8'h47); put(8'h02); put(8'hFE); put(8'h7D);
        put_crc();
        send_burst();
        chk(np == 2, "R6 pixel count", np, 2);
        chk(pq[0] == 24'hFC8044, "R6 pixel 0", pq[0], 24'hFC8044);
        chk(pq[1] == 24'h00FC7C, "R6 pixel 1", pq[1], 24'h00FC7C);
    endtask

    task automatic t_b2b();
        int nsop;
        bit order_ok;
        clear_logs();
        put_short(8'h21, 8'h00);
        put_hdr(8'h3E, 6);
        put(8'hA1); put(8'hA2); put(8'hA3); put(8'hB1); put(8'hB2); put(8'hB3);
        put_crc();
        put_short(8'h31, 8'h00);
        put_short(8'h08, 8'h0F);
        for (int i = 0; i < nb; i++) dq[i] = 8'hxx;
        begin
            logic [7:0] ref_q [0:23];
            for (int i = 0; i < 24; i++) ref_q[i] = bq[i];
            send_burst();
            order_ok = 1'b1;
            nsop = 0;
            for (int i = 0; i < 24; i++) begin
                if (dq[i] !== ref_q[i]) order_ok = 1'b0;
                if (sq[i]) nsop++;
            end
        end
        chk(nd == 24, "R3 merged byte count", nd, 24);
        chk(order_ok, "R3 merged byte order", order_ok, 1);
        chk(nsop == 4 && sq[0] && sq[4] && sq[16] && sq[20], "R3 sop marks", nsop, 4);
        chk(np == 2 && pq[1] == 24'hB1B2B3, "R8 pixels in mixed burst", pq[1], 24'hB1B2B3);
        chk(hsync == 0 && err_type == 0, "R8 hsync after end", {hsync, err_type}, 0);
    endtask

    task automatic t_order();
        clear_logs();
        lane_order = 8'h1B;                   // logical i <- physical 3-i
        put_hdr(8'h3E, 6);
        put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h05); put(8'h06);
        put_crc();
        send_burst();
        chk(np == 2 && pq[0] == 24'h010203, "R2 reversed map pixel 0", pq[0], 24'h010203);
        chk(pq[1] == 24'h040506, "R2 reversed map pixel 1", pq[1], 24'h040506);
        lane_order = 8'h4E;                   // 2,3,0,1
        clear_logs();
        put_short(8'h21, 8'h00);
        send_burst();
        chk(hsync == 1 && nd == 4 && dq[0] == 8'h21, "R2 swapped map sync", dq[0], 8'h21);
        put_short(8'h31, 8'h00);
        send_burst();
        lane_order = 8'hE4;
    endtask

    task automatic t_skip();
        clear_logs();
        put_hdr(8'h09, 2); put(8'h21); put(8'h00); put_crc();
        put_hdr(8'h19, 6);
        put(8'h01); put(8'h00); put(8'h00); put(8'h00); put(8'h21); put(8'h00);
        put_crc();
        put_short(8'h08, 8'h00);
        send_burst();
        chk(vsync == 0 && hsync == 0, "R7 sync untouched", {vsync, hsync}, 0);
        chk(np == 0 && err_type == 0, "R7 no pixel no error", np, 0);
    endtask

    task automatic t_wc0();
        clear_logs();
        put_hdr(8'h3E, 0); put_crc();
        put_hdr(8'h3E, 0); put_crc();
        put_hdr(8'h3E, 6);
        put(8'h0A); put(8'h0B); put(8'h0C); put(8'h0D); put(8'h0E); put(8'h0F);
        put_crc();
        send_burst();
        chk(np == 2 && pq[0] == 24'h0A0B0C, "R8 empty packets", pq[0], 24'h0A0B0C);
    endtask

    task automatic t_trunc();
        clear_logs();
        put_hdr(8'h3E, 30);
        put(8'h77); put(8'h88); put(8'h99); put(8'h21);
        send_burst();
        chk(np == 1, "R12 partial pixel dropped", np, 1);
        put_short(8'h01, 8'h00);
        send_burst();
        chk(vsync == 1 && hsync == 0, "R11 restart at header", {vsync, hsync}, 2);
        chk(np == 1, "R11 no pixel from header", np, 1);
        put_short(8'h11, 8'h00);
        send_burst();
    endtask

    task automatic t_unknown();
        chk(err_type == 0, "R10 error clear before", err_type, 0);
        put_short(8'h05, 8'h00);
        send_burst();
        chk(err_type == 1, "R10 unknown short", err_type, 1);
        clear_logs();
        put_hdr(8'h29, 6);
        put(8'h21); put(8'h00); put(8'h00); put(8'h00); put(8'h01); put(8'h00);
        put_crc();
        put_hdr(8'h3E, 6);
        put(8'hD1); put(8'hD2); put(8'hD3); put(8'hE1); put(8'hE2); put(8'hE3);
        put_crc();
        send_burst();
        chk(hsync == 0 && vsync == 0, "R10 unknown long skipped", {vsync, hsync}, 0);
        chk(np == 2 && pq[1] == 24'hE1E2E3, "R10 next packet decoded", pq[1], 24'hE1E2E3);
        chk(err_type == 1, "R10 error sticky", err_type, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync();
        t_pix24();
        t_pix18();
        t_b2b();
        t_order();
        t_skip();
        t_wc0();
        t_trunc();
        t_unknown();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule